// File: doc/BRIEF.md
# Multi-Level Page-Table Walker

This block translates a virtual address into a physical address by walking an in-memory radix page table, one entry read per level. It supports three paging geometries: a two-level mode with 32-bit addresses, a three-level mode with 39-bit addresses and a four-level mode with 48-bit addresses. A bare mode passes the address straight through. The caller pulses `start` with the address, the access kind, the mode and the translation-control word. The walker then issues entry reads over a request/response port and ends with a single-cycle `done` that carries either a translation or a fault code.

On success the walker reports the physical address, the leaf entry, the leaf entry's address and its level, and a global flag gathered across the walk. It also reports the address-space identifier taken from the control word. The leaf permission check is reduced to the `perm_ok` input. The walker does not write accessed/dirty bits back to memory. It only computes the entry value a write-back would store and flags whether that write-back is needed.

The controller has four states. `ST_IDLE` waits for a start. `ST_FETCH` issues one entry read. `ST_WAIT` waits for the response and judges the entry. `ST_DONE` presents the result for one cycle. The transitions are:
- launch: `ST_IDLE` to `ST_FETCH`, on a start with a good address.
- reject: `ST_IDLE` to `ST_DONE`, on a non-canonical address.
- sent: `ST_FETCH` to `ST_WAIT`.
- descend: `ST_WAIT` to `ST_FETCH`, on a pointer entry above level 0.
- finish: `ST_WAIT` to `ST_DONE`, on a leaf, a fault or a memory error.
- retire: `ST_DONE` to `ST_IDLE`.

Top module: `pt_walker`

## Requirements
- R1: With `mode`=0 (bare), a start gives `done`=1 in the same cycle with `paddr`=`vaddr` and `fault_code`=0. No memory read is made and `busy` stays low.
- R2: In mode 2 (39-bit) and mode 3 (48-bit), a start whose bits above the top address bit differ from that bit ends one cycle later with `fault_code`=1 and no memory read. Mode 1 (32-bit) makes no such check and uses only `vaddr[31:0]`.
- R3: The walk begins at level 1, 2 or 3 for modes 1, 2 or 3. The root base is the control word's PPN field shifted left by 12; that field is bits 21:0 in mode 1 and bits 43:0 otherwise. Each entry address is the table base plus the level-j index shifted left by 2 (mode 1) or 3 (otherwise). The level-j index is taken from bit 12 + j×w, with w=10 in mode 1 and w=9 otherwise.
- R4: `mem_req` is a one-cycle pulse, one per level visited. `busy` is high from the cycle after start through the single-cycle `done`, and both are low in the next cycle. With a memory that answers one cycle after the request, `done` comes 2k+1 cycles after the start edge, where k is the number of reads.
- R5: A response with `mem_err`=1 ends the walk with `fault_code`=2.
- R6: An entry is invalid when V (bit 0) is 0, or when W (bit 2) is 1 and R (bit 1) is 0. An invalid entry, or a pointer (R, W and X all 0; X is bit 3) read at level 0, ends the walk with `fault_code`=3.
- R7: The entry PPN is bits 31:10 in mode 1 and bits 53:10 otherwise. Bits 63:54 of a 64-bit entry do not affect the address. A pointer above level 0 makes PPN<<12 the next table base.
- R8: A leaf above level 0 whose lowest level×w PPN bits are not all zero gives `fault_code`=4. Otherwise those PPN bits are replaced by the matching virtual page-number bits. `paddr` is that PPN above the 12-bit page offset, and `leaf_level` gives the leaf's level.
- R9: `global_hit` is the OR of the G bit (bit 5) of every valid entry read during the walk.
- R10: `upd_pte` is the leaf with A (bit 6) set, plus D (bit 7) set when D is clear and `acc_kind` is 1 (write) or 3 (read-modify-write); kinds 0 (read) and 2 (execute) do not set D. `upd_needed` is 1 when either bit had to change.
- R11: `asid` is control-word bits 30:22 zero-extended in mode 1, and bits 59:44 otherwise.
- R12: A leaf with `perm_ok`=0 ends the walk with `fault_code`=5. This check takes priority over the misaligned-superpage fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| vaddr | input | 64 | Virtual address |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 read-modify-write |
| mode | input | 2 | 0 bare, 1 32-bit, 2 39-bit, 3 48-bit |
| xlat_ctl | input | 64 | Translation-control word |
| perm_ok | input | 1 | Leaf permission verdict |
| mem_req | output | 1 | Entry read request pulse |
| mem_addr | output | 64 | Entry address |
| mem_resp | input | 1 | Read response strobe |
| mem_err | input | 1 | Read error with the response |
| mem_rdata | input | 64 | Entry data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Fault code is nonzero |
| fault_code | output | 3 | 0 none, 1 bad address, 2 access, 3 invalid entry, 4 misaligned, 5 permission |
| paddr | output | 64 | Physical address |
| leaf_pte | output | 64 | Leaf entry (mode 1 zero-extended) |
| leaf_addr | output | 64 | Address of the leaf entry |
| leaf_level | output | 2 | Level of the leaf |
| global_hit | output | 1 | OR of G bits on the walk |
| asid | output | 16 | Address-space identifier |
| upd_pte | output | 64 | Leaf with A/D bits updated |
| upd_needed | output | 1 | Update differs from leaf |

## Verification
Results have fixed latencies:
- The bare result appears in the same cycle as the start pulse, so it is sampled a moment after `start` is driven.
- A non-canonical address finishes on the first negative edge after the start edge.
- Each entry read adds two cycles, one to request and one to receive. The bench memory answers exactly one cycle after each request, so `done` is due at negative edge 2k+1.

The bench counts negative edges from the start edge and samples every result output on the cycle where `done` rises. It checks that this count equals 2k+1 for the number of requests it saw, and that `busy` was high on every earlier edge. It samples once more on the following edge to confirm that `done` and `busy` have dropped.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
    localparam int XW      = 64;
    localparam int PG_OFFS = 12;
    localparam int PPN_LSB = 10;
    localparam int LVL_W   = 2;
    localparam int ASID_W  = 16;
    localparam int FLT_W   = 3;

    localparam int B_V = 0;
    localparam int B_R = 1;
    localparam int B_W = 2;
    localparam int B_X = 3;
    localparam int B_G = 5;
    localparam int B_A = 6;
    localparam int B_D = 7;

    typedef enum logic [1:0] {
        MODE_BARE = 2'd0,
        MODE_S32  = 2'd1,
        MODE_S39  = 2'd2,
        MODE_S48  = 2'd3
    } pg_mode_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RMW   = 2'd3
    } acc_kind_e;

    typedef enum logic [FLT_W-1:0] {
        FLT_NONE     = 3'd0,
        FLT_BADVA    = 3'd1,
        FLT_ACCESS   = 3'd2,
        FLT_INVALID  = 3'd3,
        FLT_MISALIGN = 3'd4,
        FLT_PERM     = 3'd5
    } fault_e;

    function automatic int unsigned idx_w(pg_mode_e m);
        return (m == MODE_S32) ? 32'd10 : 32'd9;
    endfunction

    function automatic int unsigned va_w(pg_mode_e m);
        case (m)
            MODE_S32: return 32'd32;
            MODE_S39: return 32'd39;
            default:  return 32'd48;
        endcase
    endfunction

    function automatic int unsigned log_esz(pg_mode_e m);
        return (m == MODE_S32) ? 32'd2 : 32'd3;
    endfunction

    function automatic int unsigned ppn_w(pg_mode_e m);
        return (m == MODE_S32) ? 32'd22 : 32'd44;
    endfunction

    function automatic logic [LVL_W-1:0] top_lvl(pg_mode_e m);
        case (m)
            MODE_S32: return 2'd1;
            MODE_S39: return 2'd2;
            default:  return 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/pt_geom.sv
module pt_geom
    import pt_walker_pkg::*;
(
    input  pg_mode_e          mode,
    input  logic [XW-1:0]     vaddr,
    input  logic [LVL_W-1:0]  level,
    input  logic [XW-1:0]     tbase,
    input  logic [XW-1:0]     pte_raw,
    output logic              canon_ok,
    output logic [XW-1:0]     ent_addr,
    output logic [XW-1:0]     pte_val,
    output logic [XW-1:0]     pte_ppn,
    output logic              sp_misalign,
    output logic [XW-1:0]     leaf_pa
);
    localparam logic [XW-1:0] ONE  = XW'(1);
    localparam logic [XW-1:0] ALL1 = '1;

    int unsigned   iw, vw, les, pw, lsh, lowb;
    logic [XW-1:0] upper, idx, low_mask, vpns;

    always_comb begin
        iw   = idx_w(mode);
        vw   = va_w(mode);
        les  = log_esz(mode);
        pw   = ppn_w(mode);
        lowb = 32'(level) * iw;
        lsh  = PG_OFFS + lowb;

        // sign-extension test above the top address bit
        upper    = vaddr >> (vw - 1);
        canon_ok = (mode == MODE_S32) || (upper == '0) || (upper == (ALL1 >> (vw - 1)));

        idx      = (vaddr >> lsh) & ((ONE << iw) - ONE);
        ent_addr = tbase + (idx << les);

        pte_val  = (mode == MODE_S32) ? {32'b0, pte_raw[31:0]} : pte_raw;
        pte_ppn  = (pte_val >> PPN_LSB) & ((ONE << pw) - ONE);

        // superpage: PPN bits below the leaf level must be zero
        low_mask    = (ONE << lowb) - ONE;
        sp_misalign = |(pte_ppn & low_mask);
        vpns        = (vaddr & ((ONE << vw) - ONE)) >> PG_OFFS;
        leaf_pa     = ((pte_ppn | (vpns & low_mask)) << PG_OFFS)
                    | (vaddr & ((ONE << PG_OFFS) - ONE));
    end
endmodule

// File: rtl/pt_ad_update.sv
module pt_ad_update
    import pt_walker_pkg::*;
(
    input  logic [XW-1:0] pte,
    input  acc_kind_e     acc,
    output logic [XW-1:0] upd_pte,
    output logic          upd_needed
);
    logic set_a, set_d;

    always_comb begin
        set_a   = !pte[B_A];
        set_d   = !pte[B_D] && (acc == ACC_WRITE || acc == ACC_RMW);
        upd_pte = pte;
        if (set_a || set_d) upd_pte[B_A] = 1'b1;
        if (set_d)          upd_pte[B_D] = 1'b1;
        upd_needed = set_a || set_d;
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [XW-1:0]     vaddr,
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        mode,
    input  logic [XW-1:0]     xlat_ctl,
    input  logic              perm_ok,
    output logic              mem_req,
    output logic [XW-1:0]     mem_addr,
    input  logic              mem_resp,
    input  logic              mem_err,
    input  logic [XW-1:0]     mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [FLT_W-1:0]  fault_code,
    output logic [XW-1:0]     paddr,
    output logic [XW-1:0]     leaf_pte,
    output logic [XW-1:0]     leaf_addr,
    output logic [LVL_W-1:0]  leaf_level,
    output logic              global_hit,
    output logic [ASID_W-1:0] asid,
    output logic [XW-1:0]     upd_pte,
    output logic              upd_needed
);
    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT, ST_DONE} st_e;

    st_e              state, nxt;
    pg_mode_e         mode_in, mode_q, g_mode;
    acc_kind_e        acc_q;
    logic [XW-1:0]    va_q, base_q, pa_q, pte_q, eaddr_q, g_va, root_base;
    logic [LVL_W-1:0] lvl_q;
    logic [ASID_W-1:0] asid_q, asid_in;
    logic             g_q;
    fault_e           fault_q, resp_fault;

    logic             canon_ok, sp_misalign, is_inv, is_ptr, descend, bare_hit, launch;
    logic [XW-1:0]    ent_addr, pte_val, pte_ppn, leaf_pa;
    logic             unused_ctl_bits;

    assign unused_ctl_bits = ^{xlat_ctl[63:60], xlat_ctl[31]};
    assign mode_in = pg_mode_e'(mode);
    assign g_mode  = (state == ST_IDLE) ? mode_in : mode_q;
    assign g_va    = (state == ST_IDLE) ? vaddr   : va_q;

    pt_geom u_geom (
        .mode(g_mode), .vaddr(g_va), .level(lvl_q), .tbase(base_q),
        .pte_raw(mem_rdata), .canon_ok(canon_ok), .ent_addr(ent_addr),
        .pte_val(pte_val), .pte_ppn(pte_ppn), .sp_misalign(sp_misalign),
        .leaf_pa(leaf_pa)
    );

    pt_ad_update u_ad (
        .pte(pte_q), .acc(acc_q), .upd_pte(upd_pte), .upd_needed(upd_needed)
    );

    // decode of the start request and of the returned entry
    always_comb begin
        bare_hit  = (state == ST_IDLE) && start && (mode_in == MODE_BARE);
        launch    = (state == ST_IDLE) && start && (mode_in != MODE_BARE);
        root_base = (mode_in == MODE_S32) ? (XW'(xlat_ctl[21:0]) << PG_OFFS)
                                          : (XW'(xlat_ctl[43:0]) << PG_OFFS);
        asid_in   = (mode_in == MODE_S32) ? {7'b0, xlat_ctl[30:22]} : xlat_ctl[59:44];

        is_inv  = !pte_val[B_V] || (pte_val[B_W] && !pte_val[B_R]);
        is_ptr  = !pte_val[B_R] && !pte_val[B_W] && !pte_val[B_X];
        descend = mem_resp && !mem_err && !is_inv && is_ptr && (lvl_q != '0);

        if (mem_err)                resp_fault = FLT_ACCESS;
        else if (is_inv)            resp_fault = FLT_INVALID;
        else if (is_ptr)            resp_fault = (lvl_q == '0) ? FLT_INVALID : FLT_NONE;
        else if (!perm_ok)          resp_fault = FLT_PERM;
        else if (sp_misalign)       resp_fault = FLT_MISALIGN;
        else                        resp_fault = FLT_NONE;

        nxt = state;
        unique case (state)
            ST_IDLE:  if (launch) nxt = canon_ok ? ST_FETCH : ST_DONE;
            ST_FETCH: nxt = ST_WAIT;
            ST_WAIT:  if (mem_resp) nxt = descend ? ST_FETCH : ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
        endcase
    end

    // state register and walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mode_q  <= MODE_BARE;
            acc_q   <= ACC_READ;
            va_q    <= '0;
            base_q  <= '0;
            lvl_q   <= '0;
            asid_q  <= '0;
            g_q     <= 1'b0;
            fault_q <= FLT_NONE;
            pa_q    <= '0;
            pte_q   <= '0;
            eaddr_q <= '0;
        end else begin
            state <= nxt;
            if (launch) begin
                mode_q  <= mode_in;
                acc_q   <= acc_kind_e'(acc_kind);
                va_q    <= vaddr;
                base_q  <= root_base;
                lvl_q   <= top_lvl(mode_in);
                asid_q  <= asid_in;
                g_q     <= 1'b0;
                fault_q <= canon_ok ? FLT_NONE : FLT_BADVA;
                pa_q    <= '0;
                pte_q   <= '0;
                eaddr_q <= '0;
            end else if (state == ST_WAIT && mem_resp) begin
                fault_q <= resp_fault;
                if (!mem_err && !is_inv) g_q <= g_q | pte_val[B_G];
                if (descend) begin
                    base_q <= pte_ppn << PG_OFFS;
                    lvl_q  <= lvl_q - 1'b1;
                end else begin
                    pte_q   <= pte_val;
                    eaddr_q <= ent_addr;
                    pa_q    <= leaf_pa;
                end
            end
        end
    end

    // outputs
    always_comb begin
        mem_req    = (state == ST_FETCH);
        mem_addr   = ent_addr;
        busy       = (state != ST_IDLE);
        done       = (state == ST_DONE) || bare_hit;
        fault_code = bare_hit ? FLT_NONE : fault_q;
        fault      = (fault_code != FLT_NONE);
        paddr      = bare_hit ? vaddr : pa_q;
        leaf_pte   = pte_q;
        leaf_addr  = eaddr_q;
        leaf_level = lvl_q;
        global_hit = g_q;
        asid       = asid_q;
    end

    p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    p_done_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_IDLE) && !mem_req);
    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    p_badva_noread_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && fault_q == FLT_BADVA) |-> $past(state) == ST_IDLE);
    p_offset_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && fault_q == FLT_NONE) |-> paddr[PG_OFFS-1:0] == va_q[PG_OFFS-1:0]);
    p_global_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> (g_q || !$past(g_q)));
    p_upd_sets_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_needed |-> upd_pte[B_A] && !$isunknown(upd_pte));
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, perm_ok = 1'b1;
    logic [63:0] vaddr = '0, xlat_ctl = '0;
    logic [1:0]  acc_kind = '0, mode = '0;
    logic        mem_req, mem_resp = 1'b0, mem_err = 1'b0;
    logic [63:0] mem_addr, mem_rdata = '0;
    logic        busy, done, fault, global_hit, upd_needed;
    logic [2:0]  fault_code;
    logic [63:0] paddr, leaf_pte, leaf_addr, upd_pte;
    logic [1:0]  leaf_level;
    logic [15:0] asid;

    always #5ns clk = ~clk;

    pt_walker u_dut (.*);

    logic [63:0] pt_mem [logic [63:0]];
    int nreads = 0, nchk = 0, nfail = 0;
    bit finished = 1'b0;

    always @(posedge clk) begin
        mem_resp <= mem_req;
        if (mem_req) begin
            nreads++;
            mem_err   <= !pt_mem.exists(mem_addr);
            mem_rdata <= pt_mem.exists(mem_addr) ? pt_mem[mem_addr] : 64'd0;
        end
    end

    localparam logic [63:0] ROOT = 64'h123;
    localparam logic [63:0] RAW1 = 64'hC3C3_F234_8A5C_3E91;
    localparam logic [63:0] RAW2 = 64'h0000_7F6B_21D7_4B6C;
    logic [63:0] ctl;

    logic        w_done, w_busyok, w_post, w_g, w_updn;
    logic [2:0]  w_fault;
    logic [63:0] w_pa, w_pte, w_addr, w_upd;
    logic [1:0]  w_lvl;
    logic [15:0] w_asid;
    int          w_lat, w_reads;

    function automatic int bl(int m);   return m == 1 ? 2 : (m == 2 ? 3 : 4); endfunction
    function automatic int biw(int m);  return m == 1 ? 10 : 9; endfunction
    function automatic int besz(int m); return m == 1 ? 4 : 8; endfunction
    function automatic int bvaw(int m); return m == 1 ? 32 : (m == 2 ? 39 : 48); endfunction

    function automatic logic [63:0] bidx(int m, logic [63:0] va, int j);
        return (va >> (12 + j * biw(m))) & ((64'd1 << biw(m)) - 64'd1);
    endfunction

    function automatic logic [63:0] canon(int m, logic [63:0] raw);
        logic [63:0] msk, v;
        if (m == 1) return raw;
        msk = (64'd1 << bvaw(m)) - 64'd1;
        v = raw & msk;
        if (v[bvaw(m)-1]) v = v | ~msk;
        return v;
    endfunction

    function automatic logic [63:0] exp_pa(int m, logic [63:0] va, int lf, logic [63:0] lppn);
        logic [63:0] low, vp;
        low = (64'd1 << (lf * biw(m))) - 64'd1;
        vp  = (va & ((64'd1 << bvaw(m)) - 64'd1)) >> 12;
        return ((lppn | (vp & low)) << 12) | (va & 64'hFFF);
    endfunction

    function automatic logic [63:0] ctl_for(int m, logic [15:0] a);
        if (m == 1) return 64'hABCD_0000_8000_0000 | (64'(a & 16'h1FF) << 22) | ROOT;
        return (64'hF << 60) | (64'(a) << 44) | ROOT;
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // pointers from the top level down to lf, leaf at lf; returns leaf entry address
    task automatic build(int m, logic [63:0] va, int lf, logic [63:0] leaf,
                         logic [63:0] gtop, output logic [63:0] laddr);
        logic [63:0] base, a;
        base = ROOT << 12;
        laddr = '0;
        for (int j = bl(m) - 1; j >= lf; j--) begin
            a = base + bidx(m, va, j) * 64'(besz(m));
            if (j == lf) begin
                pt_mem[a] = leaf;
                laddr = a;
            end else begin
                pt_mem[a] = ((64'h200 + 64'(j)) << 10) | 64'h1 | ((j == bl(m) - 1) ? gtop : 64'h0);
                base = (64'h200 + 64'(j)) << 12;
            end
        end
    endtask

    task automatic walk(int m, logic [63:0] va, int acc, bit perm);
        @(negedge clk);
        start = 1'b1; mode = 2'(m); vaddr = va; acc_kind = 2'(acc);
        perm_ok = perm; xlat_ctl = ctl; nreads = 0; w_busyok = 1'b1; w_post = 1'b1;
        if (m == 0) begin
            #1;
            w_done = done; w_pa = paddr; w_fault = fault_code; w_busyok = !busy;
            @(negedge clk); start = 1'b0; w_lat = 0;
            @(negedge clk); @(negedge clk);
        end else begin
            @(negedge clk); start = 1'b0; w_lat = 1;
            while (!done && w_lat < 200) begin
                if (!busy) w_busyok = 1'b0;
                @(negedge clk); w_lat++;
            end
            w_done = done;
            if (!busy) w_busyok = 1'b0;
            w_fault = fault_code; w_pa = paddr; w_pte = leaf_pte; w_addr = leaf_addr;
            w_lvl = leaf_level; w_g = global_hit; w_asid = asid; w_upd = upd_pte; w_updn = upd_needed;
            @(negedge clk);
            w_post = !done && !busy;
        end
        w_reads = nreads;
    endtask

    initial begin
        logic [63:0] va, lppn, leaf, la, expu;
        repeat (3) @(negedge clk);
        chk("R4 reset busy", 64'(busy), 0);
        chk("R4 reset done", 64'(done), 0);
        chk("R4 reset mem_req", 64'(mem_req), 0);
        rst_n = 1'b1;

        // R1 bare pass-through
        ctl = ctl_for(3, 16'h0);
        walk(0, RAW1, 0, 1'b1);
        chk("R1 done same cycle", 64'(w_done), 1);
        chk("R1 paddr", w_pa, RAW1);
        chk("R1 fault", 64'(w_fault), 0);
        chk("R1 busy low", 64'(w_busyok), 1);
        chk("R1 no read", 64'(w_reads), 0);

        // sweep: every mode, every leaf level, two address patterns (R3 R7 R8 R11 R4)
        for (int m = 1; m <= 3; m++) begin
            for (int p = 0; p < 2; p++) begin
                for (int lf = 0; lf < bl(m); lf++) begin
                    pt_mem.delete();
                    va   = canon(m, p ? RAW2 : RAW1);
                    lppn = (64'h5A0 + 64'(m)) << (lf * biw(m));
                    leaf = (lppn << 10) | 64'hCF | ((m != 1) ? (64'h3FF << 54) : 64'h0);
                    build(m, va, lf, leaf, 64'h0, la);
                    ctl = ctl_for(m, (m == 1) ? 16'h1A5 : 16'hBEEF);
                    walk(m, va, 0, 1'b1);
                    chk("R8 fault none", 64'(w_fault), 0);
                    chk("R8 R7 paddr", w_pa, exp_pa(m, va, lf, lppn));
                    chk("R3 leaf_addr", w_addr, la);
                    chk("R8 leaf_level", 64'(w_lvl), 64'(lf));
                    chk("R4 read count", 64'(w_reads), 64'(bl(m) - lf));
                    chk("R4 latency", 64'(w_lat), 64'(2 * (bl(m) - lf) + 1));
                    chk("R4 busy through", 64'(w_busyok), 1);
                    chk("R4 done pulse", 64'(w_post), 1);
                    chk("R11 asid", 64'(w_asid), (m == 1) ? 64'h1A5 : 64'hBEEF);
                    chk("R9 global clear", 64'(w_g), 0);
                    chk("R10 no update", 64'(w_updn), 0);
                end
            end
        end

        // R2 non-canonical addresses
        pt_mem.delete();
        ctl = ctl_for(2, 16'h1);
        walk(2, 64'h0000_0040_0000_0000, 0, 1'b1);
        chk("R2 39 fault", 64'(w_fault), 1);
        chk("R2 39 no read", 64'(w_reads), 0);
        chk("R2 39 latency", 64'(w_lat), 1);
        walk(3, 64'h8000_0000_0000_1000, 0, 1'b1);
        chk("R2 48 fault", 64'(w_fault), 1);
        chk("R2 48 no read", 64'(w_reads), 0);

        // R5 memory error on the root read
        pt_mem.delete();
        ctl = ctl_for(3, 16'h2);
        walk(3, canon(3, RAW1), 0, 1'b1);
        chk("R5 access fault", 64'(w_fault), 2);
        chk("R5 reads", 64'(w_reads), 1);

        // R6 invalid root entry, W without R, pointer at level 0
        pt_mem.delete();
        ctl = ctl_for(2, 16'h3);
        va = canon(2, RAW2);
        build(2, va, 2, 64'h0, 64'h0, la);
        walk(2, va, 0, 1'b1);
        chk("R6 V clear", 64'(w_fault), 3);
        chk("R6 V clear reads", 64'(w_reads), 1);
        pt_mem.delete();
        build(2, va, 2, (64'h1 << 28) | 64'h5, 64'h0, la);
        walk(2, va, 0, 1'b1);
        chk("R6 W without R", 64'(w_fault), 3);
        pt_mem.delete();
        ctl = ctl_for(1, 16'h4);
        va = RAW1;
        build(1, va, 0, (64'h300 << 10) | 64'h1, 64'h0, la);
        walk(1, va, 0, 1'b1);
        chk("R6 pointer at level 0", 64'(w_fault), 3);
        chk("R6 pointer reads", 64'(w_reads), 2);

        // R8 misaligned superpages
        pt_mem.delete();
        ctl = ctl_for(2, 16'h5);
        va = canon(2, RAW1);
        build(2, va, 2, (((64'h5A2 << 18) | 64'h8) << 10) | 64'hCF, 64'h0, la);
        walk(2, va, 0, 1'b1);
        chk("R8 misaligned level 2", 64'(w_fault), 4);
        pt_mem.delete();
        ctl = ctl_for(3, 16'h5);
        va = canon(3, RAW2);
        build(3, va, 1, (((64'h5A3 << 9) | 64'h100) << 10) | 64'hCF, 64'h0, la);
        walk(3, va, 0, 1'b1);
        chk("R8 misaligned level 1", 64'(w_fault), 4);
        chk("R8 misaligned reads", 64'(w_reads), 3);

        // R12 permission denied, and priority over misalignment
        pt_mem.delete();
        ctl = ctl_for(2, 16'h6);
        va = canon(2, RAW2);
        build(2, va, 0, (64'h777 << 10) | 64'hCF, 64'h0, la);
        walk(2, va, 0, 1'b0);
        chk("R12 perm fault", 64'(w_fault), 5);
        pt_mem.delete();
        build(2, va, 1, (64'h1 << 10) | 64'hCF, 64'h0, la);
        walk(2, va, 0, 1'b0);
        chk("R12 perm before misalign", 64'(w_fault), 5);

        // R9 global flag from a pointer and from the leaf
        pt_mem.delete();
        ctl = ctl_for(3, 16'h7);
        va = canon(3, RAW1);
        build(3, va, 0, (64'h888 << 10) | 64'hCF, 64'h20, la);
        walk(3, va, 0, 1'b1);
        chk("R9 global from pointer", 64'(w_g), 1);
        pt_mem.delete();
        build(2, canon(2, RAW1), 1, (64'h5A2 << 19) | 64'hEF, 64'h0, la);
        ctl = ctl_for(2, 16'h7);
        walk(2, canon(2, RAW1), 0, 1'b1);
        chk("R9 global from leaf", 64'(w_g), 1);

        // R10 accessed/dirty update over every access kind and A/D state
        ctl = ctl_for(1, 16'h8);
        for (int acc = 0; acc < 4; acc++) begin
            for (int ad = 0; ad < 4; ad++) begin
                bit sa, sd;
                pt_mem.delete();
                leaf = (64'h9AB << 10) | 64'hF | (64'(ad) << 6);
                build(1, RAW2, 0, leaf, 64'h0, la);
                walk(1, RAW2, acc, 1'b1);
                sa = !ad[0];
                sd = !ad[1] && (acc == 1 || acc == 3);
                expu = leaf | ((sa || sd) ? 64'h40 : 64'h0) | (sd ? 64'h80 : 64'h0);
                chk("R10 upd_pte", w_upd, expu);
                chk("R10 upd_needed", 64'(w_updn), 64'(sa || sd));
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL R4 watchdog got hung exp done");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule